// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the two port-to-port interrupt lines of a dual-port memory. Each side owns one mailbox word at the top of the address space. The left side posts a message by writing the highest address. That raises the right-side interrupt. The right side posts by writing the address one below the highest, which raises the left-side interrupt. The receiving side acknowledges by reading its own mailbox with output enable asserted, which drops its interrupt. The data words stay in the shared array, so this block only watches each port's control, address and busy lines.

Each interrupt is a two-state machine, FLAG_IDLE and FLAG_PENDING:
- **RAISE** moves the machine to FLAG_PENDING when a valid post arrives.
- **DROP** returns it to FLAG_IDLE when a valid acknowledge arrives and there is no post in the same cycle.
- **KEEP** holds the current state in every other cycle.

A low busy on the receiving side masks both RAISE and DROP for that side's machine. Inputs are sampled on the rising clock edge. The outputs are registered and active low.

Top module: `mbx_irq`

## Requirements
- R1: While reset is asserted and after it is released, both `l_int_n` and `r_int_n` are high (1 = no interrupt) until a post occurs.
- R2: A left write (`l_ce_n`=0, `l_rw_n`=0) to address 2^AW-1 with `r_busy_n`=1 drives `r_int_n` low from the next clock edge.
- R3: A right read (`r_ce_n`=0, `r_rw_n`=1, `r_oe_n`=0) of address 2^AW-1 with `r_busy_n`=1 drives `r_int_n` high from the next edge.
- R4: A right write to address 2^AW-2 with `l_busy_n`=1 drives `l_int_n` low from the next edge.
- R5: A left read with `l_oe_n`=0 of address 2^AW-2 with `l_busy_n`=1 drives `l_int_n` high from the next edge.
- R6: While `r_busy_n`=0, `r_int_n` does not change. While `l_busy_n`=0, `l_int_n` does not change.
- R7: If a post and an acknowledge for the same interrupt fall in the same cycle, that interrupt ends up asserted (low).
- R8: Accesses that leave an interrupt unchanged:
  - a read with output enable high;
  - any access with chip enable high;
  - any access to another address;
  - a read by the posting side;
  - a write by the receiving side.
- R9: With no post or acknowledge for an interrupt, its output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read/write, 1 = read, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left address |
| l_busy_n | input | 1 | Left busy, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read/write, 1 = read, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right address |
| r_busy_n | input | 1 | Right busy, active low |
| l_int_n | output | 1 | Interrupt toward the left port, active low |
| r_int_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The assertions assume that every control, address and busy input is a known value, stable across each rising edge and synchronous to `clk`. They also assume that reset is held for at least one edge. The bench changes all inputs only on the falling edge and never drives X. Its stimulus mixes directed cases with pseudo-random cycles biased toward the two mailbox addresses. This keeps the posts, acknowledges, busy masks and same-cycle collisions inside these assumptions while exercising them densely.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int AW = 14,
    parameter logic [AW-1:0] POST_ADDR = '1,
    parameter logic [AW-1:0] ACK_ADDR  = '1
) (
    input  logic          ce_n,
    input  logic          rw_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic          post_hit,
    output logic          ack_hit
);
    logic wr_cyc;
    logic rd_cyc;

    always_comb begin
        wr_cyc   = !ce_n && !rw_n;
        rd_cyc   = !ce_n && rw_n && !oe_n;
        post_hit = wr_cyc && (addr == POST_ADDR);
        ack_hit  = rd_cyc && (addr == ACK_ADDR);
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic ack,
    input  logic busy_n,
    output logic int_n
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (busy_n) begin
            unique case (state_q)
                FLAG_IDLE:    if (post) state_d = FLAG_PENDING;
                FLAG_PENDING: if (ack && !post) state_d = FLAG_IDLE;
                default:      state_d = FLAG_IDLE;
            endcase
        end
    end

    always_comb begin
        int_n = (state_q != FLAG_PENDING);
    end

    // R2
    post_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post && busy_n) |=> !int_n);
    // R3
    ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !post && busy_n) |=> int_n);
    // R6
    busy_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |=> $stable(int_n));
    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!post && !ack) |=> $stable(int_n));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce_n,
    input  logic          l_rw_n,
    input  logic          l_oe_n,
    input  logic [AW-1:0] l_addr,
    input  logic          l_busy_n,
    input  logic          r_ce_n,
    input  logic          r_rw_n,
    input  logic          r_oe_n,
    input  logic [AW-1:0] r_addr,
    input  logic          r_busy_n,
    output logic          l_int_n,
    output logic          r_int_n
);
    localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

    logic [NUM_PORTS-1:0]        p_ce_n;
    logic [NUM_PORTS-1:0]        p_rw_n;
    logic [NUM_PORTS-1:0]        p_oe_n;
    logic [NUM_PORTS-1:0][AW-1:0] p_addr;
    logic [NUM_PORTS-1:0]        p_post;
    logic [NUM_PORTS-1:0]        p_ack;

    assign p_ce_n = {r_ce_n, l_ce_n};
    assign p_rw_n = {r_rw_n, l_rw_n};
    assign p_oe_n = {r_oe_n, l_oe_n};
    assign p_addr = {r_addr, l_addr};

    // Left posts to TOP and acknowledges NEXT; right does the mirror.
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        mbx_port_decode #(
            .AW        (AW),
            .POST_ADDR ((g == PORT_L) ? TOP_ADDR  : NEXT_ADDR),
            .ACK_ADDR  ((g == PORT_L) ? NEXT_ADDR : TOP_ADDR)
        ) u_dec (
            .ce_n     (p_ce_n[g]),
            .rw_n     (p_rw_n[g]),
            .oe_n     (p_oe_n[g]),
            .addr     (p_addr[g]),
            .post_hit (p_post[g]),
            .ack_hit  (p_ack[g])
        );
    end

    mbx_flag_fsm u_flag_r (
        .clk    (clk),
        .rst_n  (rst_n),
        .post   (p_post[PORT_L]),
        .ack    (p_ack[PORT_R]),
        .busy_n (r_busy_n),
        .int_n  (r_int_n)
    );

    mbx_flag_fsm u_flag_l (
        .clk    (clk),
        .rst_n  (rst_n),
        .post   (p_post[PORT_R]),
        .ack    (p_ack[PORT_L]),
        .busy_n (l_busy_n),
        .int_n  (l_int_n)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (l_int_n && r_int_n));
    // R2
    left_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && !l_rw_n && l_addr == TOP_ADDR && r_busy_n) |=> !r_int_n);
    // R4
    right_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n && !r_rw_n && r_addr == NEXT_ADDR && l_busy_n) |=> !l_int_n);
    // R8
    no_touch_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n && (r_ce_n || r_oe_n || !r_rw_n)) |=> $stable(r_int_n));
endmodule

// File: tb/tb_mbx_irq.sv
module tb_mbx_irq;
    localparam int AW = 14;
    localparam logic [AW-1:0] TOP  = {AW{1'b1}};
    localparam logic [AW-1:0] NEXT = TOP - 1'b1;

    logic clk = 1'b0;
    logic rst_n;
    logic l_ce_n, l_rw_n, l_oe_n, l_busy_n;
    logic r_ce_n, r_rw_n, r_oe_n, r_busy_n;
    logic [AW-1:0] l_addr, r_addr;
    logic l_int_n, r_int_n;

    int total = 0;
    int bad = 0;
    bit exp_l = 0;
    bit exp_r = 0;

    always #2 clk = ~clk;

    mbx_irq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .l_int_n(l_int_n), .r_int_n(r_int_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input bit post, input bit ack, input bit busy_n,
                                     input string post_t, input string ack_t);
        if (!busy_n && (post || ack)) return "R6";
        if (post && ack) return "R7";
        if (post) return post_t;
        if (ack) return ack_t;
        return "R8/R9";
    endfunction

    // One cycle: drive at negedge, model at posedge, compare just after.
    task automatic step(input logic lce, input logic lrw, input logic loe,
                        input logic [AW-1:0] la, input logic lb,
                        input logic rce, input logic rrw, input logic roe,
                        input logic [AW-1:0] ra, input logic rb);
        bit pr, ar, pl, al;
        string tr, tl;
        @(negedge clk);
        l_ce_n = lce; l_rw_n = lrw; l_oe_n = loe; l_addr = la; l_busy_n = lb;
        r_ce_n = rce; r_rw_n = rrw; r_oe_n = roe; r_addr = ra; r_busy_n = rb;
        pr = !lce && !lrw && la == TOP;
        ar = !rce && rrw && !roe && ra == TOP;
        pl = !rce && !rrw && ra == NEXT;
        al = !lce && lrw && !loe && la == NEXT;
        tr = tag_of(pr, ar, rb, "R2", "R3");
        tl = tag_of(pl, al, lb, "R4", "R5");
        @(posedge clk);
        if (rb) begin
            if (pr) exp_r = 1;
            else if (ar) exp_r = 0;
        end
        if (lb) begin
            if (pl) exp_l = 1;
            else if (al) exp_l = 0;
        end
        #1;
        check(tr, r_int_n, !exp_r);
        check(tl, l_int_n, !exp_l);
    endtask

    localparam logic [AW-1:0] X0 = 14'h0123;

    initial begin : watchdog
        #400000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0;
        l_ce_n = 1; l_rw_n = 1; l_oe_n = 1; l_addr = '0; l_busy_n = 1;
        r_ce_n = 1; r_rw_n = 1; r_oe_n = 1; r_addr = '0; r_busy_n = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", l_int_n, 1'b1);
        check("R1", r_int_n, 1'b1);
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1;
        check("R1", r_int_n, 1'b1);

        // R2 left post, R8 read with oe high, wrong side read
        step(0,0,1,TOP,1, 1,1,1,X0,1);
        step(1,1,1,X0,1,  0,1,1,TOP,1);
        step(0,1,0,TOP,1, 1,1,1,X0,1);
        // R3 ack
        step(1,1,1,X0,1,  0,1,0,TOP,1);
        // R4 right post, R8 other address, R5 ack
        step(1,1,1,X0,1,  0,0,1,NEXT,1);
        step(0,1,0,X0,1,  0,0,1,X0,1);
        step(0,1,0,NEXT,1, 1,1,1,X0,1);
        // R6 busy masks set and clear
        step(0,0,1,TOP,1, 1,1,1,X0,0);
        step(0,0,1,TOP,1, 1,1,1,X0,1);
        step(1,1,1,X0,1,  0,1,0,TOP,0);
        step(1,1,1,X0,0,  0,0,1,NEXT,1);
        // R7 collisions
        step(0,0,1,TOP,1, 0,1,0,TOP,1);
        step(0,1,0,NEXT,1, 0,0,1,NEXT,1);
        step(0,1,0,NEXT,1, 0,0,1,NEXT,1);
        // R9 quiet cycles
        step(1,1,1,X0,1, 1,1,1,X0,1);
        step(1,1,1,X0,1, 1,1,1,X0,1);

        for (int i = 0; i < 2000; i++) begin
            logic [AW-1:0] la, ra;
            int sl, sr;
            sl = $urandom_range(0, 3);
            sr = $urandom_range(0, 3);
            la = (sl == 0) ? TOP : (sl == 1) ? NEXT : (sl == 2) ? AW'($urandom) : TOP;
            ra = (sr == 0) ? TOP : (sr == 1) ? NEXT : (sr == 2) ? AW'($urandom) : NEXT;
            step($urandom_range(0,3) == 0, 1'($urandom), 1'($urandom), la, $urandom_range(0,4) != 0,
                 $urandom_range(0,3) == 0, 1'($urandom), 1'($urandom), ra, $urandom_range(0,4) != 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule